// File: doc/BRIEF.md
# Constant-Time Branch Resolution Unit

This unit works out where instruction fetch goes after a conditional branch. Each cycle a branch may be issued with its program counter, a flag that marks a 16-bit instruction, the comparison result and a signed branch offset. One cycle later the unit reports whether fetch must be redirected and to which address. The comparator, the program counter register and the fetch side are outside the unit.

The unit has a protected timing mode for code whose run time must not reveal secret data. The mode exists only when the build parameter `SECURE_EN` is set, and it takes effect only while the run-time input `secure_mode_i` is also high. In this mode every branch redirects. A branch that is not taken goes to the next sequential instruction, so both outcomes show the same cycle count and the same activity. When the build parameter `SEP_TGT_ADDER` selects a separate target adder, branches in this mode take one extra stall cycle. The outcome then selects between two stored addresses in that second cycle and does not sit in front of the target-address mux.

Top module: `ct_branch_resolver`

## Requirements
- R1: While reset is asserted and at the first sample after it, `redirect_o` and `stall_o` are 0 and `target_o` is 0.
- R2: With the protected mode inactive, a taken branch issued at a clock edge gives `redirect_o`=1 right after that edge, with `target_o` = `pc_i` + sign-extended `offset_i` (modulo 2^AW) and bit 0 cleared.
- R3: With the protected mode inactive, a not-taken branch gives `redirect_o`=0 and `stall_o`=0 after the issuing edge.
- R4: With the protected mode active, a not-taken branch redirects to the next sequential instruction, and a taken branch redirects to the taken target.
- R5: The next sequential address is `pc_i`+2 when `is_compressed_i`=1 and `pc_i`+4 when it is 0, modulo 2^AW.
- R6: The protected mode is active only when `SECURE_EN`=1 and `secure_mode_i`=1. With `SECURE_EN`=0 the run-time bit has no effect on any output.
- R7: With `SEP_TGT_ADDER`=1 and the protected mode active, `stall_o`=1 and `redirect_o`=0 right after the issuing edge. At the next edge `redirect_o` becomes 1 and `stall_o` becomes 0. The issue-to-redirect count is 2 cycles for both outcomes.
- R8: With `SEP_TGT_ADDER`=0, `stall_o` is never 1 and a protected-mode branch redirects right after the issuing edge.
- R9: Bit 0 of `target_o` is 0 whenever `redirect_o` is 1, even for an odd offset.
- R10: `target_o` is 0 whenever `redirect_o` is 0. A redirect from a single issue lasts one cycle.
- R11: `br_valid_i` is ignored while `stall_o` is 1. The held branch completes normally and no further stall or redirect follows from the ignored issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | A conditional branch is issued this cycle |
| pc_i | input | AW | Address of the branch instruction |
| is_compressed_i | input | 1 | 1 for a 16-bit instruction, 0 for a 32-bit instruction |
| cond_taken_i | input | 1 | Comparison result, 1 when the branch is taken |
| offset_i | input | OW | Signed branch offset in bytes |
| secure_mode_i | input | 1 | Run-time request for constant-time branching |
| redirect_o | output | 1 | Fetch must restart at `target_o` |
| target_o | output | AW | Redirect address, halfword aligned |
| stall_o | output | 1 | Branch is held for its extra resolution cycle |

## Verification
The bench runs three parameter sets side by side so that a wrong choice of latency variant shows up as a mismatch on one of them. It aims at a not-taken branch in the protected mode: a design that drops the redirect, or that points it at the taken target or at a fixed +4 for compressed code, gives a wrong or missing redirect. Odd offsets, negative offsets and addresses near the top of the space check that bit 0 is cleared and that the adders wrap. A design that leaks the outcome through timing gives different issue-to-redirect counts for the two outcomes. A design that accepts an issue while it stalls gives a second stall.

// File: rtl/ct_br_pkg.sv
package ct_br_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } br_seq_state_e;

endpackage

// File: rtl/ct_br_tgt_calc.sv
module ct_br_tgt_calc #(
  parameter int AW = 32,
  parameter int OW = 13
) (
  input  logic [AW-1:0] pc_i,
  input  logic          is_compressed_i,
  input  logic [OW-1:0] offset_i,
  output logic [AW-1:0] seq_addr_o,
  output logic [AW-1:0] tkn_addr_o
);

  localparam int EXT = AW - OW;
  localparam logic [AW-1:0] HALF_MASK = {{(AW-1){1'b1}}, 1'b0};

  logic [AW-1:0] step;
  logic [AW-1:0] off_sext;

  always_comb begin
    step       = is_compressed_i ? AW'(2) : AW'(4);
    off_sext   = {{EXT{offset_i[OW-1]}}, offset_i};
    seq_addr_o = (pc_i + step) & HALF_MASK;
    tkn_addr_o = (pc_i + off_sext) & HALF_MASK;
  end

endmodule

// File: rtl/ct_br_sequencer.sv
module ct_br_sequencer
  import ct_br_pkg::*;
#(
  parameter int AW            = 32,
  parameter int SEP_TGT_ADDER = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          taken_i,
  input  logic          secure_i,
  input  logic [AW-1:0] seq_addr_i,
  input  logic [AW-1:0] tkn_addr_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          stall_o
);

  br_seq_state_e state_q, state_d;
  logic          redir_q, redir_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          hold_en;
  logic          defer;
  logic          hold_tkn_q;
  logic [AW-1:0] hold_seq_q, hold_tgt_q;

  // Deferred resolution happens only with the separate adder in protected mode.
  generate
    if (SEP_TGT_ADDER != 0) begin : g_sep
      assign defer = secure_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_tkn_q <= 1'b0;
          hold_seq_q <= '0;
          hold_tgt_q <= '0;
        end else if (hold_en) begin
          hold_tkn_q <= taken_i;
          hold_seq_q <= seq_addr_i;
          hold_tgt_q <= tkn_addr_i;
        end
      end
    end else begin : g_fused
      assign defer      = 1'b0;
      assign hold_tkn_q = 1'b0;
      assign hold_seq_q = '0;
      assign hold_tgt_q = '0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    redir_d = 1'b0;
    tgt_d   = '0;
    hold_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (issue_i) begin
          if (defer) begin
            state_d = ST_HOLD;
            hold_en = 1'b1;
          end else begin
            redir_d = taken_i | secure_i;
            if (taken_i)       tgt_d = tkn_addr_i;
            else if (secure_i) tgt_d = seq_addr_i;
          end
        end
      end
      ST_HOLD: begin
        state_d = ST_IDLE;
        redir_d = 1'b1;
        tgt_d   = hold_tkn_q ? hold_tgt_q : hold_seq_q;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      redir_q <= 1'b0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      redir_q <= redir_d;
      tgt_q   <= tgt_d;
    end
  end

  assign redirect_o = redir_q;
  assign target_o   = tgt_q;
  assign stall_o    = (state_q == ST_HOLD);

endmodule

// File: rtl/ct_branch_resolver.sv
module ct_branch_resolver #(
  parameter int AW            = 32,
  parameter int OW            = 13,
  parameter int SECURE_EN     = 1,
  parameter int SEP_TGT_ADDER = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid_i,
  input  logic [AW-1:0] pc_i,
  input  logic          is_compressed_i,
  input  logic          cond_taken_i,
  input  logic [OW-1:0] offset_i,
  input  logic          secure_mode_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          stall_o
);

  logic          sec_act;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] tkn_addr;

  generate
    if (SECURE_EN != 0) begin : g_sec
      assign sec_act = secure_mode_i;
    end else begin : g_nosec
      logic unused_mode;
      assign unused_mode = secure_mode_i;
      assign sec_act     = 1'b0;
    end
  endgenerate

  ct_br_tgt_calc #(.AW(AW), .OW(OW)) u_calc (
    .pc_i            (pc_i),
    .is_compressed_i (is_compressed_i),
    .offset_i        (offset_i),
    .seq_addr_o      (seq_addr),
    .tkn_addr_o      (tkn_addr)
  );

  ct_br_sequencer #(.AW(AW), .SEP_TGT_ADDER(SEP_TGT_ADDER)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (br_valid_i),
    .taken_i    (cond_taken_i),
    .secure_i   (sec_act),
    .seq_addr_i (seq_addr),
    .tkn_addr_i (tkn_addr),
    .redirect_o (redirect_o),
    .target_o   (target_o),
    .stall_o    (stall_o)
  );

endmodule

// File: rtl/ct_branch_resolver_chk.sv
module ct_branch_resolver_chk #(
  parameter int AW            = 32,
  parameter int SECURE_EN     = 1,
  parameter int SEP_TGT_ADDER = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid_i,
  input logic          cond_taken_i,
  input logic          secure_mode_i,
  input logic          redirect_o,
  input logic [AW-1:0] target_o,
  input logic          stall_o
);

  localparam bit HAS_SEC = (SECURE_EN != 0);
  localparam bit HAS_SEP = (SEP_TGT_ADDER != 0);

  logic sec_act;
  logic acc;
  assign sec_act = HAS_SEC && secure_mode_i;
  assign acc     = br_valid_i && !stall_o;

  p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> !target_o[0]);

  p_quiet_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> (target_o == '0));

  p_nt_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sec_act && !cond_taken_i) |=> (!redirect_o && !stall_o));

  p_fused_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sec_act && !HAS_SEP) |=> (redirect_o && !stall_o));

  p_defer_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sec_act && HAS_SEP) |=> (stall_o && !redirect_o));

  p_stall_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (redirect_o && !stall_o));

  p_taken_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sec_act && cond_taken_i) |=> redirect_o);

endmodule

bind ct_branch_resolver ct_branch_resolver_chk #(
  .AW(AW), .SECURE_EN(SECURE_EN), .SEP_TGT_ADDER(SEP_TGT_ADDER)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .br_valid_i    (br_valid_i),
  .cond_taken_i  (cond_taken_i),
  .secure_mode_i (secure_mode_i),
  .redirect_o    (redirect_o),
  .target_o      (target_o),
  .stall_o       (stall_o)
);

// File: tb/ct_branch_resolver_tb.sv
module ct_branch_resolver_tb;

  localparam int AW = 32;
  localparam int OW = 13;

  typedef struct packed {
    logic [31:0] pc;
    logic        cmp;
    logic        tk;
    logic [12:0] off;
    logic        sec;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 1'b0, 1'b1, 13'h0010, 1'b0},
    '{32'h0000_1000, 1'b0, 1'b0, 13'h0010, 1'b0},
    '{32'h0000_1000, 1'b1, 1'b0, 13'h0010, 1'b1},
    '{32'h0000_1000, 1'b0, 1'b0, 13'h0020, 1'b1},
    '{32'h0000_2000, 1'b0, 1'b1, 13'h1FF0, 1'b1},
    '{32'h0000_2000, 1'b1, 1'b1, 13'h1FF0, 1'b0},
    '{32'h0000_3002, 1'b0, 1'b1, 13'h0005, 1'b0},
    '{32'hFFFF_FFFE, 1'b0, 1'b0, 13'h0000, 1'b1},
    '{32'hFFFF_FFFC, 1'b0, 1'b1, 13'h0008, 1'b0},
    '{32'h0000_0000, 1'b1, 1'b0, 13'h0FFE, 1'b0},
    '{32'h0000_0004, 1'b1, 1'b1, 13'h1000, 1'b1}
  };

  logic          clk;
  logic          rst_n;
  logic          br_valid;
  logic [AW-1:0] pc;
  logic          cmp;
  logic          tk;
  logic [OW-1:0] off;
  logic          sec;

  logic          a_red, b_red, c_red;
  logic [AW-1:0] a_tgt, b_tgt, c_tgt;
  logic          a_stl, b_stl, c_stl;

  int n_chk;
  int n_fail;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  ct_branch_resolver #(.AW(AW), .OW(OW), .SECURE_EN(1), .SEP_TGT_ADDER(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid), .pc_i(pc),
    .is_compressed_i(cmp), .cond_taken_i(tk), .offset_i(off),
    .secure_mode_i(sec), .redirect_o(a_red), .target_o(a_tgt), .stall_o(a_stl));

  ct_branch_resolver #(.AW(AW), .OW(OW), .SECURE_EN(1), .SEP_TGT_ADDER(0)) u_dut_fused (
    .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid), .pc_i(pc),
    .is_compressed_i(cmp), .cond_taken_i(tk), .offset_i(off),
    .secure_mode_i(sec), .redirect_o(b_red), .target_o(b_tgt), .stall_o(b_stl));

  ct_branch_resolver #(.AW(AW), .OW(OW), .SECURE_EN(0), .SEP_TGT_ADDER(1)) u_dut_nosec (
    .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid), .pc_i(pc),
    .is_compressed_i(cmp), .cond_taken_i(tk), .offset_i(off),
    .secure_mode_i(sec), .redirect_o(c_red), .target_o(c_tgt), .stall_o(c_stl));

  function automatic logic [31:0] f_seq(logic [31:0] p, logic c);
    return (p + (c ? 32'd2 : 32'd4)) & 32'hFFFF_FFFE;
  endfunction

  function automatic logic [31:0] f_tkn(logic [31:0] p, logic [12:0] o);
    return (p + {{19{o[12]}}, o}) & 32'hFFFF_FFFE;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(vec_t v);
    @(negedge clk);
    br_valid = 1'b1; pc = v.pc; cmp = v.cmp; tk = v.tk; off = v.off; sec = v.sec;
    @(posedge clk);
    #1 br_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; br_valid = 1'b0; pc = '0; cmp = 1'b0; tk = 1'b0; off = '0; sec = 1'b1;
    #23;
    chk("R1 redirect in reset", 32'(a_red), 32'd0);
    chk("R1 stall in reset", 32'(a_stl), 32'd0);
    chk("R1 target in reset", a_tgt, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 redirect after reset", 32'(a_red | b_red | c_red), 32'd0);
    chk("R1 stall after reset", 32'(a_stl | b_stl | c_stl), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] exp_t;
      logic        b_r;
      v = VECS[i];
      exp_t = v.tk ? f_tkn(v.pc, v.off) : f_seq(v.pc, v.cmp);
      issue(v);
      // first sample, right after the issuing edge
      if (v.sec) begin
        chk("R7 stall raised", 32'(a_stl), 32'd1);
        chk("R7 no early redirect", 32'(a_red), 32'd0);
      end else begin
        chk(v.tk ? "R2 redirect" : "R3 no redirect", 32'(a_red), 32'(v.tk));
        chk(v.tk ? "R2 target" : "R10 target idle", a_tgt, v.tk ? exp_t : 32'd0);
        chk("R3 no stall", 32'(a_stl), 32'd0);
      end
      b_r = v.tk | v.sec;
      chk("R8 fused redirect", 32'(b_red), 32'(b_r));
      chk(v.sec ? "R4 fused target" : "R5 fused target", b_tgt, b_r ? exp_t : 32'd0);
      chk("R8 fused no stall", 32'(b_stl), 32'd0);
      chk("R6 disabled redirect", 32'(c_red), 32'(v.tk));
      chk("R6 disabled stall", 32'(c_stl), 32'd0);
      chk("R6 disabled target", c_tgt, v.tk ? exp_t : 32'd0);
      @(posedge clk); #1;
      if (v.sec) begin
        chk("R7 late redirect", 32'(a_red), 32'd1);
        chk("R4 late target", a_tgt, exp_t);
        chk("R7 stall released", 32'(a_stl), 32'd0);
        chk("R9 bit0", 32'(a_tgt[0]), 32'd0);
      end else begin
        chk("R10 single pulse", 32'(a_red), 32'd0);
      end
      chk("R10 fused pulse", 32'(b_red), 32'd0);
      chk("R10 fused target idle", b_tgt, 32'd0);
    end

    // R7: equal issue-to-redirect count for both outcomes
    begin
      int lat_t, lat_n;
      vec_t vt, vn;
      vt = '{32'h0000_5000, 1'b0, 1'b1, 13'h0040, 1'b1};
      vn = '{32'h0000_5000, 1'b0, 1'b0, 13'h0040, 1'b1};
      issue(vt); lat_t = 1;
      for (int k = 0; k < 5 && !a_red; k++) begin @(posedge clk); #1; lat_t++; end
      @(posedge clk); #1;
      issue(vn); lat_n = 1;
      for (int k = 0; k < 5 && !a_red; k++) begin @(posedge clk); #1; lat_n++; end
      chk("R7 equal latency", lat_t, lat_n);
      chk("R7 latency two", lat_t, 32'd2);
      @(posedge clk); #1;
    end

    // R11: issue held high during the stall cycle is ignored
    @(negedge clk);
    br_valid = 1'b1; pc = 32'h0000_6000; cmp = 1'b0; tk = 1'b0; off = 13'h0100; sec = 1'b1;
    @(negedge clk);
    pc = 32'h0000_7000; tk = 1'b1;
    chk("R11 stalling", 32'(a_stl), 32'd1);
    @(posedge clk); #1;
    br_valid = 1'b0;
    chk("R11 held branch target", a_tgt, 32'h0000_6004);
    chk("R11 no second stall", 32'(a_stl), 32'd0);
    @(posedge clk); #1;
    chk("R11 no second redirect", 32'(a_red), 32'd0);
    chk("R11 idle stall", 32'(a_stl), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule